// File: doc/BRIEF.md
# Register Rename Map with Freelist

This block performs explicit register renaming for an out-of-order core. A table maps every architectural register onto an entry in a larger physical register file. When an instruction is renamed, its source operands are translated through the table. Its destination receives a fresh physical register taken from a freelist, and the table entry is overwritten. The physical register previously held by that destination is reported to the caller. The reorder buffer hands that register back through the commit port once the overwriting instruction retires.

Branches snapshot the table and the freelist into a small ring of checkpoint slots. On a misprediction the caller names the slot. The table is then restored, and every register allocated after the branch becomes free again. Frees that committed between the snapshot and the recovery stay honoured. A correctly predicted branch releases the oldest slot. Branches must resolve in the order they were renamed.

Top module: `rmap_top`

## Requirements
- R1: After reset, architectural register i maps to physical register i, and physical registers ARCH_N..PHYS_N-1 are free. The first destination renamed after reset receives physical register ARCH_N.
- R2: Source physical indices come from the table as it stood before the same instruction's destination update. An instruction that reads and writes r1 therefore gets the old mapping of r1 as its source.
- R3: A destination is given the lowest-numbered free physical register. The previous mapping of that architectural register is reported in `out_old_phys`.
- R4: With ZERO_REG set, a destination of architectural register 0 allocates nothing and reports `out_dst_valid`=0. Register 0 always reads as physical register 0.
- R5: A physical register handed back on the commit port becomes free and can be chosen by the next allocation.
- R6: `ren_ready` is 0 when a destination is needed and no physical register is free. Instructions without a destination are still accepted.
- R7: A branch takes checkpoint slots in ring order 0,1,..,CKPT_N-1 and reports the slot in `out_ckpt_id`. `ren_ready` is 0 for a branch while CKPT_N slots are outstanding.
- R8: Recovery to a slot restores the table to its state just after that branch. Registers allocated after the branch return to the freelist.
- R9: A register freed at commit after a checkpoint was taken stays free after recovery to that checkpoint.
- R10: Recovery discards the named slot and all younger slots. A release frees the oldest outstanding slot.
- R11: Results appear on the registered outputs one cycle after an accepted rename. No rename is accepted in a recovery cycle (`ren_ready`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| ren_valid | input | 1 | rename request |
| ren_has_dst | input | 1 | instruction writes a register |
| ren_dst | input | AW | architectural destination |
| ren_src1 | input | AW | architectural source 1 |
| ren_src2 | input | AW | architectural source 2 |
| ren_is_branch | input | 1 | instruction needs a checkpoint |
| ren_ready | output | 1 | request can be accepted this cycle |
| out_valid | output | 1 | renamed result valid |
| out_dst_valid | output | 1 | a new register was allocated |
| out_dst_phys | output | PW | allocated physical register |
| out_old_phys | output | PW | previous mapping, to free at commit |
| out_src1_phys | output | PW | translated source 1 |
| out_src2_phys | output | PW | translated source 2 |
| out_ckpt_id | output | CW | checkpoint slot of a branch |
| commit_valid | input | 1 | return a physical register |
| commit_phys | input | PW | register being returned |
| recover_valid | input | 1 | misprediction recovery |
| recover_id | input | CW | checkpoint slot to restore |
| release_valid | input | 1 | oldest branch resolved correctly |

## Verification
The bench goes after recovery that follows a commit made during speculation. A design that restored the stale freelist snapshot would leak that register, and a later allocation would skip the lowest index. It also checks reading and writing the same register in one instruction. A design that bypassed the new mapping would return the new physical index as the source. Other targets are exhausting the freelist, where a wrong stall condition either hands out a busy register or blocks instructions without a destination, and filling the checkpoint ring, where a wrong full count lets a fifth branch overwrite the oldest live snapshot.

// File: rtl/rmap_pkg.sv
package rmap_pkg;
  localparam int unsigned DEF_ARCH_N = 32;
  localparam int unsigned DEF_PHYS_N = 64;
  localparam int unsigned DEF_CKPT_N = 4;
endpackage

// File: rtl/rmap_lowest.sv
module rmap_lowest #(
  parameter int unsigned N = 64,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/rmap_ckpt.sv
module rmap_ckpt #(
  parameter int unsigned ARCH_N = 32,
  parameter int unsigned PHYS_N = 64,
  parameter int unsigned CKPT_N = 4,
  localparam int unsigned PW = $clog2(PHYS_N),
  localparam int unsigned CW = $clog2(CKPT_N),
  localparam int unsigned MW = ARCH_N * PW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CW-1:0]     wr_idx,
  input  logic [MW-1:0]     wr_map,
  input  logic [PHYS_N-1:0] wr_free,
  input  logic [PHYS_N-1:0] commit_mask,
  input  logic [CW-1:0]     rd_idx,
  output logic [MW-1:0]     rd_map,
  output logic [PHYS_N-1:0] rd_free
);
  logic [MW-1:0]     snap_map  [CKPT_N];
  logic [PHYS_N-1:0] snap_free [CKPT_N];

  for (genvar c = 0; c < CKPT_N; c++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        snap_map[c]  <= '0;
        snap_free[c] <= '0;
      end else if (wr_en && wr_idx == CW'(c)) begin
        snap_map[c]  <= wr_map;
        snap_free[c] <= wr_free;
      end else begin
        snap_free[c] <= snap_free[c] | commit_mask;
      end
    end
  end

  assign rd_map  = snap_map[rd_idx];
  assign rd_free = snap_free[rd_idx];
endmodule

// File: rtl/rmap_top.sv
module rmap_top
  import rmap_pkg::*;
#(
  parameter int unsigned ARCH_N   = DEF_ARCH_N,
  parameter int unsigned PHYS_N   = DEF_PHYS_N,
  parameter int unsigned CKPT_N   = DEF_CKPT_N,
  parameter bit          ZERO_REG = 1'b1,
  localparam int unsigned AW = $clog2(ARCH_N),
  localparam int unsigned PW = $clog2(PHYS_N),
  localparam int unsigned CW = $clog2(CKPT_N),
  localparam int unsigned MW = ARCH_N * PW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ren_valid,
  input  logic          ren_has_dst,
  input  logic [AW-1:0] ren_dst,
  input  logic [AW-1:0] ren_src1,
  input  logic [AW-1:0] ren_src2,
  input  logic          ren_is_branch,
  output logic          ren_ready,
  output logic          out_valid,
  output logic          out_dst_valid,
  output logic [PW-1:0] out_dst_phys,
  output logic [PW-1:0] out_old_phys,
  output logic [PW-1:0] out_src1_phys,
  output logic [PW-1:0] out_src2_phys,
  output logic [CW-1:0] out_ckpt_id,
  input  logic          commit_valid,
  input  logic [PW-1:0] commit_phys,
  input  logic          recover_valid,
  input  logic [CW-1:0] recover_id,
  input  logic          release_valid
);
  logic [PW-1:0]     map_q [ARCH_N];
  logic [PHYS_N-1:0] free_q;
  logic [CW:0]       ck_head, ck_tail, ck_count;
  logic              ck_full, needs_dst, fire, found;
  logic [PW-1:0]     alloc_idx;
  logic [PHYS_N-1:0] commit_mask, alloc_mask, free_after;
  logic [MW-1:0]     map_flat_next, ck_rd_map;
  logic [PHYS_N-1:0] ck_rd_free;
  logic [CW-1:0]     rec_offset;

  rmap_lowest #(.N(PHYS_N)) u_pick (
    .vec(free_q), .found(found), .idx(alloc_idx)
  );

  assign ck_count  = ck_tail - ck_head;
  assign ck_full   = ck_count == (CW+1)'(CKPT_N);
  assign needs_dst = ren_has_dst && !(ZERO_REG && ren_dst == '0);
  assign ren_ready = !recover_valid && (!needs_dst || found) &&
                     (!ren_is_branch || !ck_full);
  assign fire      = ren_valid && ren_ready;

  always_comb begin
    commit_mask = '0;
    alloc_mask  = '0;
    if (commit_valid) commit_mask[commit_phys] = 1'b1;
    if (fire && needs_dst) alloc_mask[alloc_idx] = 1'b1;
  end
  assign free_after = (free_q & ~alloc_mask) | commit_mask;

  always_comb begin
    for (int i = 0; i < ARCH_N; i++) begin
      if (fire && needs_dst && ren_dst == AW'(i))
        map_flat_next[i*PW +: PW] = alloc_idx;
      else
        map_flat_next[i*PW +: PW] = map_q[i];
    end
  end

  rmap_ckpt #(.ARCH_N(ARCH_N), .PHYS_N(PHYS_N), .CKPT_N(CKPT_N)) u_ckpt (
    .clk(clk), .rst(rst),
    .wr_en(fire && ren_is_branch), .wr_idx(ck_tail[CW-1:0]),
    .wr_map(map_flat_next), .wr_free(free_after),
    .commit_mask(commit_mask),
    .rd_idx(recover_id), .rd_map(ck_rd_map), .rd_free(ck_rd_free)
  );

  assign rec_offset = recover_id - ck_head[CW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ARCH_N; i++) map_q[i] <= PW'(i);
      for (int p = 0; p < PHYS_N; p++) free_q[p] <= (p >= ARCH_N);
      ck_head <= '0;
      ck_tail <= '0;
    end else begin
      if (recover_valid) begin
        for (int i = 0; i < ARCH_N; i++) map_q[i] <= ck_rd_map[i*PW +: PW];
        free_q  <= ck_rd_free | commit_mask;
        ck_tail <= ck_head + {1'b0, rec_offset};
      end else begin
        for (int i = 0; i < ARCH_N; i++) map_q[i] <= map_flat_next[i*PW +: PW];
        free_q <= free_after;
        if (fire && ren_is_branch) ck_tail <= ck_tail + 1'b1;
      end
      if (release_valid) ck_head <= ck_head + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_dst_valid <= 1'b0;
      out_dst_phys  <= '0;
      out_old_phys  <= '0;
      out_src1_phys <= '0;
      out_src2_phys <= '0;
      out_ckpt_id   <= '0;
    end else begin
      out_valid     <= fire;
      out_dst_valid <= fire && needs_dst;
      out_dst_phys  <= alloc_idx;
      out_old_phys  <= map_q[ren_dst];
      out_src1_phys <= map_q[ren_src1];
      out_src2_phys <= map_q[ren_src2];
      out_ckpt_id   <= ck_tail[CW-1:0];
    end
  end

  // R3: the encoder may only hand out a register the freelist holds
  a_r3_alloc_is_free: assert property (@(posedge clk) disable iff (rst)
    fire && needs_dst |-> free_q[alloc_idx]);
  // R3: a new register never equals the mapping it replaces
  a_r3_new_not_old: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_dst_valid |-> out_dst_phys != out_old_phys);
  // R7: outstanding checkpoints stay within the ring
  a_r7_ckpt_bound: assert property (@(posedge clk) disable iff (rst)
    ck_count <= (CW+1)'(CKPT_N));
  // R11: a recovery cycle produces no renamed result
  a_r11_quiet_recover: assert property (@(posedge clk) disable iff (rst)
    recover_valid |=> !out_valid);
  // R4: register zero keeps physical register zero
  a_r4_zero_fixed: assert property (@(posedge clk) disable iff (rst)
    ZERO_REG |-> map_q[0] == '0);
  // R6: an empty freelist blocks a request that needs a destination
  a_r6_stall_empty: assert property (@(posedge clk) disable iff (rst)
    free_q == '0 && needs_dst |-> !ren_ready);
endmodule

// File: tb/rmap_top_tb.sv
module rmap_top_tb;
  localparam int AN = 32, PN = 64, CN = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic ren_valid = 0, ren_has_dst = 0, ren_is_branch = 0;
  logic [4:0] ren_dst = 0, ren_src1 = 0, ren_src2 = 0;
  logic ren_ready, out_valid, out_dst_valid;
  logic [5:0] out_dst_phys, out_old_phys, out_src1_phys, out_src2_phys;
  logic [1:0] out_ckpt_id;
  logic commit_valid = 0, recover_valid = 0, release_valid = 0;
  logic [5:0] commit_phys = 0;
  logic [1:0] recover_id = 0;

  always #10 clk = ~clk;

  rmap_top u_dut (
    .clk(clk), .rst(rst), .ren_valid(ren_valid), .ren_has_dst(ren_has_dst),
    .ren_dst(ren_dst), .ren_src1(ren_src1), .ren_src2(ren_src2),
    .ren_is_branch(ren_is_branch), .ren_ready(ren_ready),
    .out_valid(out_valid), .out_dst_valid(out_dst_valid),
    .out_dst_phys(out_dst_phys), .out_old_phys(out_old_phys),
    .out_src1_phys(out_src1_phys), .out_src2_phys(out_src2_phys),
    .out_ckpt_id(out_ckpt_id), .commit_valid(commit_valid),
    .commit_phys(commit_phys), .recover_valid(recover_valid),
    .recover_id(recover_id), .release_valid(release_valid)
  );

  int checks = 0, errors = 0;
  int mmap [AN];
  bit [PN-1:0] mfree;
  int cmap [CN][AN];
  bit [PN-1:0] cfree [CN];
  int chead = 0, ctail = 0;

  typedef struct { int s1; int s2; int dv; int d; int o; int ck; string req; } exp_t;
  exp_t q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int lowest_free();
    for (int p = 0; p < PN; p++) if (mfree[p]) return p;
    return -1;
  endfunction

  task automatic do_ren(input int dst, input bit has, input int s1, input int s2,
                        input bit br, input string req);
    bit need, rdy;
    exp_t e;
    @(negedge clk);
    ren_valid = 1; ren_has_dst = has; ren_dst = 5'(dst);
    ren_src1 = 5'(s1); ren_src2 = 5'(s2); ren_is_branch = br;
    #1;
    need = has && dst != 0;
    rdy = (!need || mfree != 0) && (!br || (ctail - chead) < CN);
    chk(ren_ready == rdy, req, "ren_ready", int'(ren_ready), int'(rdy));
    if (rdy) begin
      e.req = req; e.s1 = mmap[s1]; e.s2 = mmap[s2];
      e.dv = need; e.d = -1; e.o = -1; e.ck = -1;
      if (need) begin
        e.d = lowest_free(); e.o = mmap[dst];
        mfree[e.d] = 0; mmap[dst] = e.d;
      end
      if (br) begin
        e.ck = ctail % CN;
        cmap[e.ck] = mmap; cfree[e.ck] = mfree;
        ctail++;
      end
      q.push_back(e);
    end
    @(posedge clk); #1;
    ren_valid = 0; ren_is_branch = 0;
  endtask

  task automatic do_commit(input int p);
    @(negedge clk);
    commit_valid = 1; commit_phys = 6'(p);
    mfree[p] = 1;
    for (int c = 0; c < CN; c++) cfree[c][p] = 1;
    @(posedge clk); #1 commit_valid = 0;
  endtask

  task automatic do_recover(input int id);
    @(negedge clk);
    recover_valid = 1; recover_id = 2'(id);
    #1 chk(ren_ready == 0, "R11", "ren_ready during recover", int'(ren_ready), 0);
    mmap = cmap[id]; mfree = cfree[id];
    ctail = chead + ((id - (chead % CN) + CN) % CN);
    @(posedge clk); #1 recover_valid = 0;
  endtask

  task automatic do_release();
    @(negedge clk);
    release_valid = 1; chead++;
    @(posedge clk); #1 release_valid = 0;
  endtask

  // monitor: pops expected results as the design produces them
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q.size() == 0) begin
        chk(0, "R11", "unexpected out_valid", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(out_src1_phys == 6'(e.s1), e.req, "src1", int'(out_src1_phys), e.s1);
        chk(out_src2_phys == 6'(e.s2), e.req, "src2", int'(out_src2_phys), e.s2);
        chk(out_dst_valid == 1'(e.dv), e.req, "dst_valid", int'(out_dst_valid), e.dv);
        if (e.dv) begin
          chk(out_dst_phys == 6'(e.d), e.req, "dst", int'(out_dst_phys), e.d);
          chk(out_old_phys == 6'(e.o), e.req, "old", int'(out_old_phys), e.o);
        end
        if (e.ck >= 0)
          chk(out_ckpt_id == 2'(e.ck), e.req, "ckpt", int'(out_ckpt_id), e.ck);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < AN; i++) mmap[i] = i;
    for (int p = 0; p < PN; p++) mfree[p] = (p >= AN);
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(ren_ready == 1, "R1", "ready after reset", int'(ren_ready), 1);
    chk(out_valid == 0, "R1", "out_valid after reset", int'(out_valid), 0);
    // R1 R2 R3: first allocation 32, source reads old r1
    do_ren(1, 1, 1, 2, 0, "R2");
    do_ren(1, 1, 1, 3, 0, "R3");
    // R4: destination r0 allocates nothing
    do_ren(0, 1, 0, 1, 0, "R4");
    // R5: freed register 1 is the lowest and is reused
    do_commit(1);
    do_ren(7, 1, 7, 1, 0, "R5");
    // R8 R9: checkpoint, speculate, commit during speculation, recover
    do_ren(0, 0, 1, 7, 1, "R7");
    do_ren(2, 1, 2, 1, 0, "R8");
    do_ren(1, 1, 2, 1, 0, "R8");
    do_commit(32);
    do_ren(3, 1, 1, 2, 0, "R9");
    do_recover(0);
    do_ren(2, 1, 1, 2, 0, "R9");
    do_ren(4, 1, 2, 3, 0, "R8");
    // R7 R10: fill the ring, stall, release, recover a middle slot
    for (int b = 0; b < CN; b++) begin
      do_ren(0, 0, 4, 2, 1, "R7");
      do_ren(5 + b, 1, 4, 5 + b, 0, "R7");
    end
    do_ren(0, 0, 1, 1, 1, "R7");
    do_release();
    do_ren(0, 0, 4, 1, 1, "R10");
    do_recover((chead + 2) % CN);
    do_ren(6, 1, 6, 7, 1, "R10");
    do_ren(9, 1, 5, 6, 0, "R10");
    // R6: exhaust the freelist
    while (mfree != 0) do_ren(10, 1, 10, 9, 0, "R6");
    do_ren(11, 1, 10, 11, 0, "R6");
    do_ren(0, 0, 10, 11, 0, "R6");
    do_commit(40);
    do_ren(12, 1, 10, 12, 0, "R5");
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R11", "pending results", q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule